// File: doc/BRIEF.md
# Rewindable FIFO with Half-Level Indicator

This block is a single-clock first-in/first-out buffer for 9-bit words. Its depth is a power-of-two parameter. Writes and reads are requested through active-low strobes that are sampled on the clock. A word moves only on the clock edge where a strobe is first seen low, so a strobe held low for many cycles moves one word. Three active-low status outputs report full, empty and more-than-half occupancy.

In standalone mode (`chain_mode` low), a falling edge on `rewind_n` moves the read side back to storage location zero. The words written since reset can then be read out again, and the write side stays where it is. In chained mode (`chain_mode` high), rewind is disabled. The half-level output then carries a one-cycle low pulse each time a word is written into the last storage location, so a downstream buffer can take over.

The read port shows the most recently read word, with `rdata_vld` high, while the read strobe is low. While the read strobe is high it shows zero with `rdata_vld` low.

Top module: `rt_fifo`

## Requirements
- R1: Reset (`rst_n` low at a clock edge) puts both pointers at location zero, the first storage location. After reset `empty_n`=0, `full_n`=1, `half_xo_n`=1, `rdata`=0 and `rdata_vld`=0.
- R2: A write happens on the first clock edge at which `wr_n` is seen low after being high. `wdata` is stored at that edge. A write attempt while `full_n` is low is dropped and stores nothing.
- R3: A read happens on the first clock edge at which `rd_n` is seen low after being high, and returns words in write order. A read attempt while `empty_n` is low leaves the read position and `rdata` unchanged.
- R4: `empty_n` is low exactly when the stored count is 0. `full_n` is low exactly when the stored count equals DEPTH. Each flag clears right after one accepted operation of the opposite kind.
- R5: In standalone mode, `half_xo_n` goes low at the edge of the write that raises the count above DEPTH/2.
- R6: In standalone mode, once low, `half_xo_n` returns high only at the clock edge where `rd_n` is seen rising with the count at or below DEPTH/2. A falling read strobe alone never clears it.
- R7: In standalone mode, a falling edge on `rewind_n` with `wr_n` and `rd_n` both high moves the read position to location zero. The write position is unchanged. The count becomes the write position, or DEPTH if that position is zero after the write side has wrapped. `half_xo_n` is then set to show whether this count exceeds DEPTH/2.
- R8: A rewind edge has no effect while `wr_n` or `rd_n` is low, or while `chain_mode` is high.
- R9: In chained mode, `half_xo_n` is high except for exactly one clock cycle after a write into location DEPTH-1, when it is low.
- R10: While `rd_n` is low, `rdata` holds the last word read and `rdata_vld` is 1. While `rd_n` is high, `rdata` is 0 and `rdata_vld` is 0.
- R11: A read and a write that start at the same edge are both performed when the flags allow them, and the count is unchanged. At an empty buffer only the write is done.
- R12: A strobe held low for several cycles performs one operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chain_mode | input | 1 | 0 = standalone, 1 = chained |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | 9 | Write data |
| rd_n | input | 1 | Active-low read strobe |
| rewind_n | input | 1 | Active-low rewind request |
| rdata | output | 9 | Read data, zero while `rd_n` is high |
| rdata_vld | output | 1 | High while `rd_n` is low |
| full_n | output | 1 | Low when full |
| empty_n | output | 1 | Low when empty |
| half_xo_n | output | 1 | Half-level flag (standalone) or last-location pulse (chained) |

## Verification
Properties check on every cycle that:
- write and read attempts against a full or empty buffer leave the pointers still;
- the count never goes past DEPTH;
- the half-level flag is set by the crossing write and only cleared by a read release or a rewind;
- a rewind lands on location zero;
- the chained pulse lasts one cycle.

Only the bench scenarios can show that data comes back in order, including after a rewind of a wrapped buffer. The same holds for the rewind counts, the data-port zeroing, the blocking of rewind by a low strobe or by chained mode, and held strobes moving a single word.

// File: rtl/rt_fifo_pkg.sv
`timescale 1ns/1ps
// Shared constants for the rewindable FIFO: strobe lane numbering and data width.
package rt_fifo_pkg;
    localparam int WORD_W  = 9;
    localparam int NLANES  = 3;
    localparam int LANE_WR = 0;
    localparam int LANE_RD = 1;
    localparam int LANE_RT = 2;
endpackage

// File: rtl/rt_fifo_edges.sv
`timescale 1ns/1ps
// Strobe edge finder: registers each active-low strobe and reports the
// high-to-low transition per lane, plus the low-to-high transition of one
// selected lane. Assumes the strobes are already synchronous to clk.
module rt_fifo_edges #(
    parameter int LANES     = 3,
    parameter int RISE_LANE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lvl_n,
    output logic [LANES-1:0] fall,
    output logic             rise_sel
);
    logic [LANES-1:0] prev_n;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            // Remember last sampled level; idle (high) after reset.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_n[i] <= 1'b1;
                else        prev_n[i] <= lvl_n[i];
            end
            assign fall[i] = prev_n[i] & ~lvl_n[i];
        end
    endgenerate

    assign rise_sel = ~prev_n[RISE_LANE] & lvl_n[RISE_LANE];
endmodule

// File: rtl/rt_fifo_mem.sv
`timescale 1ns/1ps
// Storage array: one clocked write port, one combinational read port.
// Assumes the controller never writes a location that holds unread data.
module rt_fifo_mem #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    // Store the incoming word at the write address.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/rt_fifo_ptrs.sv
`timescale 1ns/1ps
// Pointer and flag controller. Keeps wrap-extended read/write pointers,
// accepts operations on strobe falling edges when the flags allow, performs
// rewinds, and produces full, empty and the half-level / last-location output.
// Assumes DEPTH is a power of two and edge inputs come from registered strobes.
module rt_fifo_ptrs #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chain_mode,
    input  logic          wr_fall,
    input  logic          rd_fall,
    input  logic          rd_rise,
    input  logic          rt_fall,
    input  logic          wr_lvl_n,
    input  logic          rd_lvl_n,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          full_n,
    output logic          empty_n,
    output logic          half_xo_n
);
    localparam logic [AW:0] FULL_C = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF_C = (AW+1)'(DEPTH / 2);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

    logic [AW:0] wptr, rptr, count, wptr_nx, rptr_nx, count_nx, rt_ptr;
    logic        is_full, is_empty, rt_go, last_w;
    logic        hf_q, xo_q, lapped;

    assign count    = wptr - rptr;
    assign is_full  = (count == FULL_C);
    assign is_empty = (count == '0);
    assign wr_go    = wr_fall & ~is_full;
    assign rd_go    = rd_fall & ~is_empty;
    assign rt_go    = rt_fall & wr_lvl_n & rd_lvl_n & ~chain_mode;
    assign last_w   = wr_go & (wptr[AW-1:0] == LAST_A);

    // Rewind target: location zero, wrap bit chosen so a wrapped full buffer reads as full.
    assign rt_ptr   = {wptr[AW] ^ ((wptr[AW-1:0] == '0) & lapped), {AW{1'b0}}};
    assign wptr_nx  = wptr + (AW+1)'(wr_go);
    assign rptr_nx  = rt_go ? rt_ptr : rptr + (AW+1)'(rd_go);
    assign count_nx = wptr_nx - rptr_nx;

    // Advance pointers on accepted operations or rewind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            wptr <= wptr_nx;
            rptr <= rptr_nx;
        end
    end

    // Half-level flag: set by the crossing write, cleared on read release, recomputed on rewind.
    always_ff @(posedge clk) begin
        if (!rst_n)                          hf_q <= 1'b1;
        else if (rt_go)                      hf_q <= !(count_nx > HALF_C);
        else if (wr_go && count_nx > HALF_C) hf_q <= 1'b0;
        else if (rd_rise && count <= HALF_C) hf_q <= 1'b1;
    end

    // Last-location pulse for chaining and the wrap memory used by rewind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xo_q   <= 1'b0;
            lapped <= 1'b0;
        end else begin
            xo_q   <= last_w & chain_mode;
            lapped <= lapped | last_w;
        end
    end

    assign waddr     = wptr[AW-1:0];
    assign raddr     = rptr[AW-1:0];
    assign full_n    = ~is_full;
    assign empty_n   = ~is_empty;
    assign half_xo_n = chain_mode ? ~xo_q : hf_q;

    a_r2_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && wr_fall) |=> $stable(wptr));
    a_r3_empty_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && rd_fall) |=> $stable(rptr));
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_C);
    a_r5_hf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !rd_go && count == HALF_C) |=> !hf_q);
    a_r6_hf_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!hf_q && !rd_rise && !rt_go) |=> !hf_q);
    a_r7_rewind_lands: assert property (@(posedge clk) disable iff (!rst_n)
        rt_go |=> (rptr[AW-1:0] == '0) && $stable(wptr));
    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        xo_q |=> !xo_q);
endmodule

// File: rtl/rt_fifo.sv
`timescale 1ns/1ps
// Rewindable FIFO top: strobe edge finder, pointer/flag controller and
// storage, plus the read-data register that drives zero while the read strobe is idle.
// Assumes all inputs are synchronous to clk.
module rt_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = rt_fifo_pkg::WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chain_mode,
    input  logic             wr_n,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd_n,
    input  logic             rewind_n,
    output logic [WIDTH-1:0] rdata,
    output logic             rdata_vld,
    output logic             full_n,
    output logic             empty_n,
    output logic             half_xo_n
);
    import rt_fifo_pkg::*;
    localparam int AW = $clog2(DEPTH);

    logic [NLANES-1:0] lvl_n, fall;
    logic              rd_rise, wr_go, rd_go;
    logic [AW-1:0]     waddr, raddr;
    logic [WIDTH-1:0]  mem_q, hold_q;

    assign lvl_n[LANE_WR] = wr_n;
    assign lvl_n[LANE_RD] = rd_n;
    assign lvl_n[LANE_RT] = rewind_n;

    rt_fifo_edges #(.LANES(NLANES), .RISE_LANE(LANE_RD)) u_edges (
        .clk(clk), .rst_n(rst_n), .lvl_n(lvl_n), .fall(fall), .rise_sel(rd_rise)
    );

    rt_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .chain_mode(chain_mode),
        .wr_fall(fall[LANE_WR]), .rd_fall(fall[LANE_RD]), .rd_rise(rd_rise),
        .rt_fall(fall[LANE_RT]), .wr_lvl_n(wr_n), .rd_lvl_n(rd_n),
        .wr_go(wr_go), .rd_go(rd_go), .waddr(waddr), .raddr(raddr),
        .full_n(full_n), .empty_n(empty_n), .half_xo_n(half_xo_n)
    );

    rt_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(wr_go), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(mem_q)
    );

    // Capture the word leaving the buffer on each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= '0;
        else if (rd_go) hold_q <= mem_q;
    end

    assign rdata     = rd_n ? '0 : hold_q;
    assign rdata_vld = ~rd_n;
endmodule

// File: tb/tb_rt_fifo.sv
`timescale 1ns/1ps
module tb_rt_fifo;
    localparam int DEPTH = 8;
    localparam int HALF  = DEPTH / 2;
    // Vector: [10:9] op (0 write, 1 read, 2 both, 3 rewind), [8:0] data
    localparam logic [10:0] VEC [16] = '{
        {2'd0, 9'h101}, {2'd0, 9'h0A2}, {2'd0, 9'h033}, {2'd1, 9'h000},
        {2'd0, 9'h1F4}, {2'd0, 9'h055}, {2'd0, 9'h166}, {2'd1, 9'h000},
        {2'd2, 9'h077}, {2'd2, 9'h188}, {2'd0, 9'h099}, {2'd3, 9'h000},
        {2'd1, 9'h000}, {2'd1, 9'h000}, {2'd0, 9'h0AA}, {2'd1, 9'h000}};

    logic clk = 0, rst_n = 0, chain_mode = 0, wr_n = 1, rd_n = 1, rewind_n = 1;
    logic [8:0] wdata = '0, rdata;
    logic rdata_vld, full_n, empty_n, half_xo_n;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [8:0] mmem [DEPTH];
    int wa, ra, cnt;
    bit lapped, hf;
    logic [8:0] last;

    always #4 clk = ~clk;

    rt_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .chain_mode(chain_mode), .wr_n(wr_n), .wdata(wdata),
        .rd_n(rd_n), .rewind_n(rewind_n), .rdata(rdata), .rdata_vld(rdata_vld),
        .full_n(full_n), .empty_n(empty_n), .half_xo_n(half_xo_n));

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_flags(input string tag);
        chk(full_n == (cnt != DEPTH), {tag, " full_n"}, 16'(full_n), 16'(cnt != DEPTH));
        chk(empty_n == (cnt != 0), {tag, " empty_n"}, 16'(empty_n), 16'(cnt != 0));
        chk(half_xo_n == (chain_mode ? 1'b1 : hf), {tag, " half_xo_n"}, 16'(half_xo_n),
            16'(chain_mode ? 1'b1 : hf));
        chk(rdata == 0 && !rdata_vld, {tag, " R10 idle port"}, 16'(rdata), 16'h0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; wr_n = 1; rd_n = 1; rewind_n = 1;
        @(posedge clk); @(negedge clk); rst_n = 1;
        wa = 0; ra = 0; cnt = 0; lapped = 0; hf = 1; last = '0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic op(input bit w, input bit r, input logic [8:0] d, input string tag);
        bit cw, cr, hit_last;
        @(negedge clk); wr_n = !w; rd_n = !r; wdata = d;
        cw = w && cnt < DEPTH;
        cr = r && cnt > 0;
        hit_last = cw && wa == DEPTH - 1;
        if (cr) begin last = mmem[ra]; ra = (ra + 1) % DEPTH; cnt--; end
        if (cw) begin mmem[wa] = d; if (wa == DEPTH - 1) lapped = 1; wa = (wa + 1) % DEPTH; cnt++; end
        if (cw && cnt > HALF) hf = 0;
        @(posedge clk); @(negedge clk);
        if (r) chk(rdata_vld && rdata == last, {tag, " R3 R10 read data"}, 16'(rdata), 16'(last));
        chk(half_xo_n == (chain_mode ? !hit_last : hf), {tag, " R5 R6 R9 mid"}, 16'(half_xo_n),
            16'(chain_mode ? !hit_last : hf));
        wr_n = 1; rd_n = 1;
        if (r && cnt <= HALF) hf = 1;
        @(posedge clk); @(negedge clk);
        check_flags(tag);
    endtask

    task automatic rewind(input string tag);
        @(negedge clk); rewind_n = 0;
        @(posedge clk); @(negedge clk); rewind_n = 1;
        if (!chain_mode) begin
            ra = 0; cnt = (wa == 0 && lapped) ? DEPTH : wa; hf = !(cnt > HALF);
        end
        @(posedge clk); @(negedge clk);
        check_flags(tag);
    endtask

    initial begin
        #(8 * 100000);
        chk(0, "watchdog", 16'h0, 16'h1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        check_flags("R1 reset");

        // Vector table walk: R2 R3 R4 R5 R6 R7 R11
        for (int i = 0; i < 16; i++) begin
            case (VEC[i][10:9])
                2'd0: op(1, 0, VEC[i][8:0], "vec R2 write");
                2'd1: op(0, 1, VEC[i][8:0], "vec R3 read");
                2'd2: op(1, 1, VEC[i][8:0], "vec R11 both");
                default: rewind("vec R7 rewind");
            endcase
        end

        // R2 R4: fill, overfill ignored, drain in order
        do_reset();
        for (int i = 0; i < DEPTH; i++) op(1, 0, 9'(9'h40 + i), "R4 fill");
        chk(full_n == 0, "R4 full after DEPTH writes", 16'(full_n), 16'h0);
        op(1, 0, 9'h1FF, "R2 write while full");
        for (int i = 0; i < DEPTH; i++) op(0, 1, 9'h0, "R2 drain");
        // R3: read while empty leaves data and position
        op(0, 1, 9'h0, "R3 empty read");
        op(1, 0, 9'h123, "R3 refill");
        op(0, 1, 9'h0, "R3 read after empty");

        // R5 R6: half-level crossing and release timing
        do_reset();
        for (int i = 0; i <= HALF; i++) op(1, 0, 9'(9'h10 + i), "R5 to half");
        chk(half_xo_n == 0, "R5 half set", 16'(half_xo_n), 16'h0);
        op(0, 1, 9'h0, "R6 release clears");
        chk(half_xo_n == 1, "R6 half clear", 16'(half_xo_n), 16'h1);

        // R8 R7: rewind blocked while read strobe low, then normal rewind
        do_reset();
        op(1, 0, 9'h011, "R8 w"); op(1, 0, 9'h022, "R8 w"); op(1, 0, 9'h033, "R8 w");
        op(0, 1, 9'h0, "R8 r");
        @(negedge clk); rd_n = 0; last = mmem[ra]; ra = ra + 1; cnt--;
        @(posedge clk); @(negedge clk); rewind_n = 0;
        @(posedge clk); @(negedge clk); rewind_n = 1; rd_n = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check_flags("R8 blocked rewind");
        op(0, 1, 9'h0, "R8 next word");
        rewind("R7 rewind");
        op(0, 1, 9'h0, "R7 first word again");

        // R12: held write strobe moves one word
        do_reset();
        @(negedge clk); wr_n = 0; wdata = 9'h0EE;
        repeat (4) @(posedge clk);
        @(negedge clk); wr_n = 1; mmem[wa] = 9'h0EE; wa++; cnt++;
        @(posedge clk); @(negedge clk);
        check_flags("R12 held write");
        op(0, 1, 9'h0, "R12 single word");

        // R11: simultaneous at empty, then both accepted
        do_reset();
        op(1, 1, 9'h0C3, "R11 both at empty");
        op(1, 1, 9'h03C, "R11 both");

        // R9 R8: chained mode pulse and disabled rewind
        chain_mode = 1;
        do_reset();
        for (int i = 0; i < DEPTH; i++) op(1, 0, 9'(9'h80 + i), "R9 chain write");
        op(0, 1, 9'h0, "R9 chain read");
        rewind("R8 chain rewind");
        op(0, 1, 9'h0, "R8 no rewind in chain");
        chain_mode = 0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule